// File: doc/BRIEF.md
# Region-Aware CPU Clock Stall Arbiter

This block produces the clock enable for a processor that shares the lower half of its address map with a video fetch engine. The processor runs at half the base clock rate. Each processor cycle is a fixed number of base beats (the `BEATS` parameter, two by default). The enable pulses on the last beat of each cycle.

At the first beat of a cycle the block records whether the processor is performing a valid access, and which half of the map that access targets. Only the top address bit decides the half. When the last beat arrives with a valid lower-half access recorded and a video request active, the block withholds the enable. It also holds the beat counter on the last beat and raises a stall flag. This state lasts until the video request drops. The enable then fires and the held cycle completes.

Upper-half accesses and idle cycles never wait, so they overlap with video fetches. The video request is granted in the same cycle that it is raised, ahead of any processor demand.

Top module: `vram_clk_arbiter`

## Requirements
- R1: While reset is high and in the first base cycle after it falls, `cpu_clk_en`, `cpu_stall` and `vid_grant` are all 0. In the second base cycle after release, `cpu_clk_en` is 1.
- R2: Without contention, `cpu_clk_en` is high for exactly one base cycle out of every `BEATS` base cycles (with the default, it alternates 0, 1).
- R3: The access type is captured from `cpu_a15` and `cpu_valid` at the clock edge that ends the first beat of a processor cycle. Changes to those inputs later in the same cycle have no effect on that cycle.
- R4: An access captured with `cpu_a15`=1 (upper half) is never stalled, even when `vid_req` is 1 on the last beat.
- R5: An access captured with `cpu_valid`=1 and `cpu_a15`=0 (lower half) that meets `vid_req`=1 on the last beat gets `cpu_stall`=1 and `cpu_clk_en`=0 in that base cycle.
- R6: A stall lasts for every base cycle in which `vid_req` stays 1. In the first base cycle with `vid_req`=0, `cpu_clk_en` is 1 and `cpu_stall` is 0, and the next processor cycle then begins.
- R7: A cycle captured with `cpu_valid`=0 is never stalled, whatever the values of `cpu_a15` and `vid_req`.
- R8: `vid_grant` equals `vid_req` in the same base cycle whenever reset is low, independently of any processor access.
- R9: `cpu_stall` and `cpu_clk_en` are never both 1. `cpu_stall`=1 only while `vid_req`=1, and a stall ends only with an enable pulse or with reset.
- R10: A video request that is active only during the first beat of a lower-half cycle, and inactive on its last beat, causes no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock (4 MHz with the default 2:1 ratio) |
| rst | input | 1 | Synchronous reset, active high |
| cpu_a15 | input | 1 | Top address bit of the processor; 1 = upper half |
| cpu_valid | input | 1 | Processor performs a memory access this cycle |
| vid_req | input | 1 | Video fetch wants the shared lower-half RAM |
| cpu_clk_en | output | 1 | Processor clock enable, one beat wide |
| vid_grant | output | 1 | Shared RAM granted to the video fetch |
| cpu_stall | output | 1 | Enable withheld this beat because of contention |

## Verification
The two functions that can fall in the same base cycle are granting RAM to a video fetch and completing a processor cycle. The bench provokes the overlap by raising `vid_req` on the last beat of processor cycles. It varies the captured half and the valid flag, and it flips the top address bit after capture.

In each overlapping beat it judges whether the enable fires alongside the grant (upper half or idle cycle) or is replaced by the stall flag (valid lower half). It also checks that the enable follows in the first beat after the request drops.

// File: rtl/vca_pkg.sv
package vca_pkg;

    // Half of the address map that a captured access targets
    typedef enum logic {
        HALF_LOWER = 1'b0,
        HALF_UPPER = 1'b1
    } map_half_e;

    // What the arbiter remembers about the current processor cycle
    typedef struct packed {
        logic      valid;
        map_half_e half;
    } cyc_info_t;

    localparam cyc_info_t CYC_IDLE = '{valid: 1'b0, half: HALF_UPPER};

    function automatic map_half_e half_of(input logic a15);
        return a15 ? HALF_UPPER : HALF_LOWER;
    endfunction

    // True when the cycle competes with video for the shared RAM
    function automatic logic needs_shared(input cyc_info_t c);
        return c.valid && (c.half == HALF_LOWER);
    endfunction

endpackage

// File: rtl/vca_beat_counter.sv
module vca_beat_counter #(
    parameter int BEATS = 2,
    localparam int PW   = (BEATS > 2) ? $clog2(BEATS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic first_beat,
    output logic last_beat
);
    logic [PW-1:0] beat_q;

    assign first_beat = (beat_q == '0);
    assign last_beat  = (beat_q == PW'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '0;
        else if (hold)
            beat_q <= beat_q;
        else if (last_beat)
            beat_q <= '0;
        else
            beat_q <= beat_q + 1'b1;
    end
endmodule

// File: rtl/vca_cycle_capture.sv
module vca_cycle_capture
    import vca_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sample,
    input  logic      a15,
    input  logic      valid,
    output cyc_info_t info
);
    cyc_info_t info_q;

    always_ff @(posedge clk) begin
        if (rst)
            info_q <= CYC_IDLE;
        else if (sample) begin
            info_q.valid <= valid;
            info_q.half  <= half_of(a15);
        end
    end

    assign info = info_q;
endmodule

// File: rtl/vram_clk_arbiter.sv
module vram_clk_arbiter
    import vca_pkg::*;
#(
    parameter int BEATS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_a15,
    input  logic cpu_valid,
    input  logic vid_req,
    output logic cpu_clk_en,
    output logic vid_grant,
    output logic cpu_stall
);
    logic      first_beat;
    logic      last_beat;
    logic      contend;
    logic      cur_lower;
    cyc_info_t cur_cyc;

    vca_beat_counter #(.BEATS(BEATS)) u_beat (
        .clk        (clk),
        .rst        (rst),
        .hold       (contend),
        .first_beat (first_beat),
        .last_beat  (last_beat)
    );

    vca_cycle_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .sample (first_beat),
        .a15    (cpu_a15),
        .valid  (cpu_valid),
        .info   (cur_cyc)
    );

    assign cur_lower = needs_shared(cur_cyc);

    // Video wins the shared RAM; a lower-half cycle waits on its last beat
    assign contend    = !rst && last_beat && cur_lower && vid_req;
    assign cpu_stall  = contend;
    assign cpu_clk_en = !rst && last_beat && !contend;
    assign vid_grant  = !rst && vid_req;
endmodule

// File: rtl/vca_checker.sv
module vca_checker (
    input logic clk,
    input logic rst,
    input logic vid_req,
    input logic cpu_clk_en,
    input logic vid_grant,
    input logic cpu_stall,
    input logic cur_lower
);
    assert_stall_excl_en_R9: assert property (@(posedge clk) disable iff (rst)
        !(cpu_stall && cpu_clk_en));

    assert_stall_needs_video_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> (vid_req && vid_grant));

    assert_stall_ends_with_en_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |=> (cpu_stall || cpu_clk_en));

    assert_stall_only_lower_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> cur_lower);

    assert_single_beat_en_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |=> !cpu_clk_en);

    assert_grant_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
        vid_grant == vid_req);

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!cpu_clk_en && !cpu_stall));
endmodule

bind vram_clk_arbiter vca_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .vid_req    (vid_req),
    .cpu_clk_en (cpu_clk_en),
    .vid_grant  (vid_grant),
    .cpu_stall  (cpu_stall),
    .cur_lower  (cur_lower)
);

// File: tb/sim_vram_clk_arbiter.sv
module sim_vram_clk_arbiter;
    localparam int CLK_PERIOD = 250;
    localparam int NVEC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_a15 = 1'b0;
    logic cpu_valid = 1'b0;
    logic vid_req = 1'b0;
    logic cpu_clk_en, vid_grant, cpu_stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vram_clk_arbiter #(.BEATS(2)) u0 (
        .clk(clk), .rst(rst), .cpu_a15(cpu_a15), .cpu_valid(cpu_valid),
        .vid_req(vid_req), .cpu_clk_en(cpu_clk_en), .vid_grant(vid_grant),
        .cpu_stall(cpu_stall)
    );

    // {a15, valid, video beats on last beat, expect stall}
    typedef struct packed {
        logic     a15;
        logic     valid;
        bit [3:0] vbeats;
        logic     exp_stall;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 4'd0, 1'b0},
        '{1'b0, 1'b1, 4'd0, 1'b0},
        '{1'b1, 1'b1, 4'd3, 1'b0},
        '{1'b0, 1'b1, 4'd1, 1'b1},
        '{1'b0, 1'b1, 4'd4, 1'b1},
        '{1'b0, 1'b0, 4'd3, 1'b0},
        '{1'b1, 1'b0, 4'd2, 1'b0},
        '{1'b0, 1'b1, 4'd6, 1'b1}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Starts at a negedge inside the first beat of a processor cycle
    task automatic run_cycle(input logic a15, input logic valid, input int vbeats,
                             input logic exp_stall);
        cpu_a15 = a15; cpu_valid = valid; vid_req = 1'b0;
        #1;
        chk("R2 first beat en low", cpu_clk_en, 1'b0);
        step();
        // R3: flip the inputs after capture; the cycle must not notice
        cpu_a15 = ~a15; cpu_valid = ~valid;
        if (exp_stall) begin
            for (int k = 0; k < vbeats; k++) begin
                vid_req = 1'b1;
                #1;
                chk("R5 stall flag", cpu_stall, 1'b1);
                chk("R5 en withheld", cpu_clk_en, 1'b0);
                chk("R8 grant", vid_grant, 1'b1);
                step();
            end
            vid_req = 1'b0;
            #1;
            chk("R6 release en", cpu_clk_en, 1'b1);
            chk("R6 release stall", cpu_stall, 1'b0);
            step();
        end else begin
            vid_req = (vbeats > 0);
            #1;
            chk("R4/R7 no stall", cpu_stall, 1'b0);
            chk("R2/R4/R7 en", cpu_clk_en, 1'b1);
            chk("R8 grant", vid_grant, vbeats > 0);
            step();
            vid_req = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        vid_req = 1'b1;
        repeat (3) step();
        #1;
        chk("R1 en in reset", cpu_clk_en, 1'b0);
        chk("R1 stall in reset", cpu_stall, 1'b0);
        chk("R1 grant in reset", vid_grant, 1'b0);
        vid_req = 1'b0;
        rst = 1'b0;
        #1;
        chk("R1 first cycle en", cpu_clk_en, 1'b0);
        chk("R1 first cycle stall", cpu_stall, 1'b0);
        step();
        #1;
        chk("R1 second cycle en", cpu_clk_en, 1'b1);
        step();

        for (int i = 0; i < NVEC; i++)
            run_cycle(VECS[i].a15, VECS[i].valid, int'(VECS[i].vbeats), VECS[i].exp_stall);

        // R10: video active only on the first beat of a lower-half cycle
        cpu_a15 = 1'b0; cpu_valid = 1'b1; vid_req = 1'b1;
        #1;
        chk("R8 grant first beat", vid_grant, 1'b1);
        chk("R10 no stall first beat", cpu_stall, 1'b0);
        step();
        vid_req = 1'b0;
        #1;
        chk("R10 en on last beat", cpu_clk_en, 1'b1);
        chk("R10 no stall last beat", cpu_stall, 1'b0);
        step();

        // R3: upper captured, then A15 drops and video arrives
        run_cycle(1'b1, 1'b1, 2, 1'b0);

        // R2: idle cadence over several cycles
        cpu_valid = 1'b0;
        for (int j = 0; j < 6; j++) begin
            #1;
            chk("R2 cadence", cpu_clk_en, (j % 2) == 1);
            step();
        end

        // Reset in the middle of a stall
        cpu_a15 = 1'b0; cpu_valid = 1'b1;
        step();
        vid_req = 1'b1;
        #1;
        chk("R5 stall before reset", cpu_stall, 1'b1);
        rst = 1'b1;
        #1;
        chk("R1 stall cleared by reset", cpu_stall, 1'b0);
        chk("R1 grant cleared by reset", vid_grant, 1'b0);
        step();
        rst = 1'b0; vid_req = 1'b0; cpu_valid = 1'b0;
        #1;
        chk("R1 restart en low", cpu_clk_en, 1'b0);
        step();
        #1;
        chk("R1 restart en high", cpu_clk_en, 1'b1);
        step();

        finish_run();
    end
endmodule